// File: doc/BRIEF.md
# Dual-Lane Float/Integer Converter

This block converts between single-precision floating-point values and 32-bit integers or 32-bit fixed-point fractions. It converts in both directions, with signed and unsigned variants of each. A fraction is a 32-bit integer scaled by 2^-32. Converting a fraction to float divides the integer by 2^32. Converting a float to a fraction multiplies the float by 2^32 before the integer conversion.

In scalar mode only the low 32-bit word is converted. In vector mode the same operation is applied to each 32-bit lane of the operand on its own, and no information passes between lanes. The conversion itself is combinational. The result and two flags, invalid and inexact, are registered behind a valid/ready handshake.

Back-pressure rules:
- The input is accepted on a clock edge where `in_valid` and `in_ready` are both high.
- `in_ready` is high whenever the output register is empty or is being drained in the same cycle.
- While `out_valid` is high and `out_ready` is low, the output holds its value and no new input is taken.

Top module: `cvt_dual`

## Requirements
- R1: `in_op` is decoded bit by bit. Bit 2 = 0 converts into float and bit 2 = 1 converts out of float. Bit 1 = 1 selects the fraction form. Bit 0 = 1 selects unsigned. An integer converts to float exactly when it fits in 24 bits. Otherwise it is rounded according to `in_rmode` (00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity), and inexact is set when bits are lost.
- R2: A fraction converts to float as the value of the integer divided by 2^32, rounded in the same way as R1.
- R3: A float converts to an integer using `in_rmode` when `in_trunc` is 0. When `in_trunc` is 1 it always rounds toward zero, whatever `in_rmode` holds. Inexact is set when a nonzero fraction is discarded.
- R4: A float converts to a fraction as the float times 2^32, rounded and range-checked as for integers.
- R5: Any NaN input to a conversion out of float gives exactly 0, sets invalid and clears inexact.
- R6: A signed result out of range, or an infinity, saturates to 0x7FFFFFFF for positive values and to 0x80000000 for negative ones. It sets invalid and clears inexact. The value -2^31 itself converts exactly.
- R7: An unsigned result above 0xFFFFFFFF saturates to 0xFFFFFFFF with invalid set. A negative value whose rounded magnitude is nonzero gives 0 with invalid set. A negative value that rounds to zero gives 0 with only inexact set.
- R8: A zero or denormal input converts out of float to 0 in every rounding mode. Inexact is set exactly when the fraction field is nonzero.
- R9: In vector mode (`in_vec` = 1), result bits 63:32 come only from operand bits 63:32 and bits 31:0 only from bits 31:0. Each flag is the OR of that flag over both lanes.
- R10: In scalar mode the upper operand word is ignored: it affects neither the result nor the flags. Result bits 63:32 are 0.
- R11: `in_ready` is high when `out_valid` is low or `out_ready` is high. An accepted input shows up with `out_valid` high on the very next cycle.
- R12: While `out_valid` is high and `out_ready` is low, `out_data`, `out_invalid` and `out_inexact` stay stable.
- R13: After reset `out_valid` is low, `in_ready` is high and `out_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and controls are valid |
| in_ready | output | 1 | Block can accept an operand |
| in_data | input | NLANES*32 | Operand, lane 0 in the low word |
| in_op | input | 3 | Operation select, see R1 |
| in_trunc | input | 1 | Float-to-integer rounds toward zero |
| in_rmode | input | 2 | Rounding mode |
| in_vec | input | 1 | 1 = all lanes, 0 = lane 0 only |
| out_valid | output | 1 | Result is valid |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | NLANES*32 | Converted result |
| out_invalid | output | 1 | NaN or saturation occurred |
| out_inexact | output | 1 | Rounding discarded nonzero bits |

## Verification
The bench builds the block with its default of two lanes. This is enough to place a NaN in one lane and an inexact value in the other, showing that the lanes stay apart while their flags are merged. It also puts a value in the upper word during scalar operations, so any leak from that word into the result or flags would be seen. Operands are picked at the exact rounding ties, at the saturation edges near ±2^31 and 2^32, and at the exponents where the fraction scaling shifts a value across the binary point.

// File: rtl/cvt_pkg.sv
package cvt_pkg;
  localparam int LANE_W     = 32;
  localparam int EXP_W      = 8;
  localparam int MAN_W      = 23;
  localparam int BIAS       = 127;
  localparam int FRAC_SHIFT = 32;

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_ZERO = 2'b01,
    RM_UP   = 2'b10,
    RM_DOWN = 2'b11
  } rmode_e;

  typedef struct packed {
    logic to_int;
    logic frac;
    logic unsgn;
  } op_t;

  typedef struct packed {
    logic [LANE_W-1:0] data;
    logic              invalid;
    logic              inexact;
  } lane_res_t;

  // Decide whether a truncated magnitude must be bumped by one unit.
  function automatic logic round_inc(rmode_e m, logic sign, logic lsb,
                                     logic g, logic s);
    case (m)
      RM_NEAR: return g & (s | lsb);
      RM_ZERO: return 1'b0;
      RM_UP:   return ~sign & (g | s);
      default: return sign & (g | s);
    endcase
  endfunction
endpackage

// File: rtl/cvt_i2f.sv
module cvt_i2f
  import cvt_pkg::*;
(
  input  logic [LANE_W-1:0] src,
  input  logic              unsgn,
  input  logic              frac,
  input  rmode_e            rmode,
  output lane_res_t         res
);
  localparam int LZ_W = $clog2(LANE_W);
  localparam int LO_W = LANE_W - 1 - MAN_W;

  logic              neg;
  logic              nz;
  logic [LANE_W-1:0] mag;
  logic [LANE_W-1:0] norm;
  logic [LZ_W-1:0]   lz;
  logic [MAN_W-1:0]  mant;
  logic              g;
  logic              s;
  logic              inc;
  logic [MAN_W:0]    mant_r;
  logic [EXP_W-1:0]  exp_b;

  always_comb begin
    neg = ~unsgn & src[LANE_W-1];
    mag = neg ? (~src + 1'b1) : src;
    nz  = |mag;
    lz  = '0;
    for (int i = 0; i < LANE_W; i++) begin
      if (mag[i]) lz = LZ_W'(LANE_W - 1 - i);
    end
    norm   = mag << lz;
    mant   = norm[LANE_W-2 -: MAN_W];
    g      = norm[LO_W-1];
    s      = |norm[LO_W-2:0];
    inc    = round_inc(rmode, neg, mant[0], g, s);
    mant_r = {1'b0, mant} + (MAN_W+1)'(inc);
    exp_b  = EXP_W'(BIAS + LANE_W - 1 - (frac ? FRAC_SHIFT : 0))
           - EXP_W'(lz) + EXP_W'(mant_r[MAN_W]);
    res.data    = nz ? {neg, exp_b, mant_r[MAN_W-1:0]} : '0;
    res.invalid = 1'b0;
    res.inexact = nz & (g | s);
  end
endmodule

// File: rtl/cvt_f2i.sv
module cvt_f2i
  import cvt_pkg::*;
(
  input  logic [LANE_W-1:0] src,
  input  logic              unsgn,
  input  logic              frac,
  input  rmode_e            rmode,
  output lane_res_t         res
);
  localparam int SH_W = 2 * LANE_W;
  localparam int E_W  = EXP_W + 2;
  localparam logic signed [E_W-1:0] BIAS_S = E_W'(BIAS);
  localparam logic signed [E_W-1:0] FRAC_S = E_W'(FRAC_SHIFT);
  localparam logic [LANE_W-1:0] SMAX = {1'b0, {(LANE_W-1){1'b1}}};
  localparam logic [LANE_W-1:0] SMIN = {1'b1, {(LANE_W-1){1'b0}}};

  logic                  sign;
  logic [EXP_W-1:0]      ex;
  logic [MAN_W-1:0]      man;
  logic                  is_nan;
  logic                  is_inf;
  logic                  is_sub;
  logic signed [E_W-1:0] e_un;
  logic [6:0]            shamt;
  logic [SH_W-1:0]       w;
  logic [LANE_W-1:0]     ipart;
  logic                  g;
  logic                  s;
  logic                  ovf;
  logic                  inc;
  logic [LANE_W:0]       mag;

  always_comb begin
    sign   = src[LANE_W-1];
    ex     = src[LANE_W-2 -: EXP_W];
    man    = src[MAN_W-1:0];
    is_nan = (&ex) & (|man);
    is_inf = (&ex) & ~(|man);
    is_sub = ~(|ex);
    e_un   = $signed({2'b00, ex}) - BIAS_S + (frac ? FRAC_S : '0);
    shamt  = 7'(e_un) + 7'(LANE_W - MAN_W);
    w      = '0;
    ipart  = '0;
    g      = 1'b0;
    s      = 1'b0;
    ovf    = 1'b0;
    if (e_un >= 0) begin
      if (e_un >= LANE_W) begin
        ovf = 1'b1;
      end else begin
        w     = SH_W'({1'b1, man}) << shamt;
        ipart = w[SH_W-1:LANE_W];
        g     = w[LANE_W-1];
        s     = |w[LANE_W-2:0];
      end
    end else begin
      g = (e_un == -1);
      s = (e_un == -1) ? |man : 1'b1;
    end
    inc = round_inc(rmode, sign, ipart[0], g, s);
    mag = {1'b0, ipart} + (LANE_W+1)'(inc);

    res = '0;
    if (is_nan) begin
      res.invalid = 1'b1;
    end else if (is_sub) begin
      res.inexact = |man;
    end else if (is_inf || ovf) begin
      res.invalid = 1'b1;
      if (unsgn) res.data = sign ? '0 : {LANE_W{1'b1}};
      else       res.data = sign ? SMIN : SMAX;
    end else if (unsgn) begin
      if (sign && (|mag)) begin
        res.invalid = 1'b1;
      end else if (mag[LANE_W]) begin
        res.invalid = 1'b1;
        res.data    = {LANE_W{1'b1}};
      end else begin
        res.data    = mag[LANE_W-1:0];
        res.inexact = g | s;
      end
    end else begin
      if (!sign && (mag > {1'b0, SMAX})) begin
        res.invalid = 1'b1;
        res.data    = SMAX;
      end else if (sign && (mag > {1'b0, SMIN})) begin
        res.invalid = 1'b1;
        res.data    = SMIN;
      end else begin
        res.data    = sign ? (~mag[LANE_W-1:0] + 1'b1) : mag[LANE_W-1:0];
        res.inexact = g | s;
      end
    end
  end
endmodule

// File: rtl/cvt_lane.sv
module cvt_lane
  import cvt_pkg::*;
(
  input  logic [LANE_W-1:0] src,
  input  op_t               op,
  input  logic              trunc,
  input  rmode_e            rmode,
  input  logic              active,
  output lane_res_t         res
);
  lane_res_t from_int;
  lane_res_t to_int;
  rmode_e    f2i_mode;

  assign f2i_mode = trunc ? RM_ZERO : rmode;

  cvt_i2f u_i2f (
    .src   (src),
    .unsgn (op.unsgn),
    .frac  (op.frac),
    .rmode (rmode),
    .res   (from_int)
  );

  cvt_f2i u_f2i (
    .src   (src),
    .unsgn (op.unsgn),
    .frac  (op.frac),
    .rmode (f2i_mode),
    .res   (to_int)
  );

  assign res = active ? (op.to_int ? to_int : from_int) : '0;
endmodule

// File: rtl/cvt_dual.sv
module cvt_dual
  import cvt_pkg::*;
#(
  parameter int NLANES = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [NLANES*LANE_W-1:0] in_data,
  input  logic [2:0]               in_op,
  input  logic                     in_trunc,
  input  logic [1:0]               in_rmode,
  input  logic                     in_vec,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [NLANES*LANE_W-1:0] out_data,
  output logic                     out_invalid,
  output logic                     out_inexact
);
  localparam int DATA_W = NLANES * LANE_W;

  lane_res_t         lane_r [NLANES];
  logic [NLANES-1:0] inv_v;
  logic [NLANES-1:0] inex_v;
  logic [DATA_W-1:0] data_c;
  logic              accept;

  for (genvar gi = 0; gi < NLANES; gi++) begin : g_lane
    cvt_lane u_lane (
      .src    (in_data[gi*LANE_W +: LANE_W]),
      .op     (op_t'(in_op)),
      .trunc  (in_trunc),
      .rmode  (rmode_e'(in_rmode)),
      .active ((gi == 0) ? 1'b1 : in_vec),
      .res    (lane_r[gi])
    );
    assign data_c[gi*LANE_W +: LANE_W] = lane_r[gi].data;
    assign inv_v[gi]  = lane_r[gi].invalid;
    assign inex_v[gi] = lane_r[gi].inexact;
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_data    <= '0;
      out_invalid <= 1'b0;
      out_inexact <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_data    <= data_c;
      out_invalid <= |inv_v;
      out_inexact <= |inex_v;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/cvt_dual_chk.sv
module cvt_dual_chk
  import cvt_pkg::*;
#(
  parameter int NLANES = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     in_valid,
  input logic                     in_ready,
  input logic [NLANES*LANE_W-1:0] in_data,
  input logic [2:0]               in_op,
  input logic                     in_trunc,
  input logic [1:0]               in_rmode,
  input logic                     in_vec,
  input logic                     out_valid,
  input logic                     out_ready,
  input logic [NLANES*LANE_W-1:0] out_data,
  input logic                     out_invalid,
  input logic                     out_inexact
);
  logic acc;
  logic lane0_nan;
  logic lane0_sub;

  assign acc       = in_valid && in_ready;
  assign lane0_nan = (&in_data[LANE_W-2 -: EXP_W]) && (|in_data[MAN_W-1:0]);
  assign lane0_sub = ~(|in_data[LANE_W-2 -: EXP_W]);

  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_invalid) && $stable(out_inexact)));

  p_nan_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[2] && lane0_nan) |=> (out_data[LANE_W-1:0] == '0 && out_invalid));

  p_denorm_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_op[2] && lane0_sub) |=> (out_data[LANE_W-1:0] == '0));

  if (NLANES > 1) begin : g_upper
    p_scalar_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && !in_vec) |=> (out_data[NLANES*LANE_W-1:LANE_W] == '0));
  end
endmodule

bind cvt_dual cvt_dual_chk #(.NLANES(NLANES)) u_chk (.*);

// File: tb/cvt_dual_test.sv
module cvt_dual_test;
  localparam int NL = 2;
  localparam logic [2:0] OP_FSI = 3'd0, OP_FUI = 3'd1, OP_FSF = 3'd2, OP_FUF = 3'd3;
  localparam logic [2:0] OP_TSI = 3'd4, OP_TUI = 3'd5, OP_TSF = 3'd6, OP_TUF = 3'd7;
  localparam logic [1:0] NE = 2'b00, TZ = 2'b01, UP = 2'b10, DN = 2'b11;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_data = '0;
  logic [2:0]  in_op = '0;
  logic        in_trunc = 1'b0;
  logic [1:0]  in_rmode = '0;
  logic        in_vec = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_data;
  logic        out_invalid;
  logic        out_inexact;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cvt_dual #(.NLANES(NL)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_op(in_op), .in_trunc(in_trunc), .in_rmode(in_rmode),
    .in_vec(in_vec), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_invalid(out_invalid), .out_inexact(out_inexact)
  );

  task automatic expect_out(string tag, logic [63:0] ed, logic ei, logic ex);
    checks++;
    if (!(out_valid === 1'b1 && out_data === ed && out_invalid === ei && out_inexact === ex)) begin
      errors++;
      $display("FAIL %s: got v=%b d=%h inv=%b inx=%b, expected v=1 d=%h inv=%b inx=%b",
               tag, out_valid, out_data, out_invalid, out_inexact, ed, ei, ex);
    end
  endtask

  task automatic xfer(string tag, logic [2:0] op, logic tr, logic [1:0] rm, logic vec,
                      logic [63:0] d, logic [63:0] ed, logic ei, logic ex);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_trunc = tr; in_rmode = rm; in_vec = vec; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out(tag, ed, ei, ex);
  endtask

  task automatic sx(string tag, logic [2:0] op, logic tr, logic [1:0] rm,
                    logic [31:0] x, logic [31:0] r, logic ei, logic ex);
    xfer(tag, op, tr, rm, 1'b0, {32'h0, x}, {32'h0, r}, ei, ex);
  endtask

  task automatic t_reset();
    checks++;
    if (!(out_valid === 1'b0 && in_ready === 1'b1 && out_data === 64'h0)) begin
      errors++;
      $display("FAIL R13: got v=%b rdy=%b d=%h, expected v=0 rdy=1 d=0", out_valid, in_ready, out_data);
    end
  endtask

  task automatic t_from_int();
    sx("R1 sint 1", OP_FSI, 0, NE, 32'h00000001, 32'h3F800000, 0, 0);
    sx("R1 sint -1", OP_FSI, 0, NE, 32'hFFFFFFFF, 32'hBF800000, 0, 0);
    sx("R1 sint min", OP_FSI, 0, NE, 32'h80000000, 32'hCF000000, 0, 0);
    sx("R1 sint 0", OP_FSI, 0, NE, 32'h00000000, 32'h00000000, 0, 0);
    sx("R1 uint max ne", OP_FUI, 0, NE, 32'hFFFFFFFF, 32'h4F800000, 0, 1);
    sx("R1 uint max tz", OP_FUI, 0, TZ, 32'hFFFFFFFF, 32'h4F7FFFFF, 0, 1);
    sx("R1 tie even", OP_FSI, 0, NE, 32'h01000001, 32'h4B800000, 0, 1);
    sx("R1 tie up", OP_FSI, 0, UP, 32'h01000001, 32'h4B800001, 0, 1);
    sx("R1 neg down", OP_FSI, 0, DN, 32'hFEFFFFFF, 32'hCB800001, 0, 1);
  endtask

  task automatic t_from_frac();
    sx("R2 sfrac -half", OP_FSF, 0, NE, 32'h80000000, 32'hBF000000, 0, 0);
    sx("R2 ufrac half", OP_FUF, 0, NE, 32'h80000000, 32'h3F000000, 0, 0);
    sx("R2 ufrac quarter", OP_FUF, 0, NE, 32'h40000000, 32'h3E800000, 0, 0);
    sx("R2 ufrac max tz", OP_FUF, 0, TZ, 32'hFFFFFFFF, 32'h3F7FFFFF, 0, 1);
  endtask

  task automatic t_to_int();
    sx("R3 2.5 ne", OP_TSI, 0, NE, 32'h40200000, 32'h00000002, 0, 1);
    sx("R3 3.5 ne", OP_TSI, 0, NE, 32'h40600000, 32'h00000004, 0, 1);
    sx("R3 2.5 up", OP_TSI, 0, UP, 32'h40200000, 32'h00000003, 0, 1);
    sx("R3 -2.5 dn", OP_TSI, 0, DN, 32'hC0200000, 32'hFFFFFFFD, 0, 1);
    sx("R3 -2.5 ne", OP_TSI, 0, NE, 32'hC0200000, 32'hFFFFFFFE, 0, 1);
    sx("R3 2.5 trunc", OP_TSI, 1, UP, 32'h40200000, 32'h00000002, 0, 1);
    sx("R3 -2.5 trunc", OP_TSI, 1, DN, 32'hC0200000, 32'hFFFFFFFE, 0, 1);
    sx("R3 1.0 exact", OP_TSI, 0, NE, 32'h3F800000, 32'h00000001, 0, 0);
    sx("R3 uint 2.5", OP_TUI, 0, NE, 32'h40200000, 32'h00000002, 0, 1);
  endtask

  task automatic t_to_frac();
    sx("R4 sfrac 0.25", OP_TSF, 0, NE, 32'h3E800000, 32'h40000000, 0, 0);
    sx("R4 sfrac -0.25", OP_TSF, 0, NE, 32'hBE800000, 32'hC0000000, 0, 0);
    sx("R4 ufrac 0.5", OP_TUF, 0, NE, 32'h3F000000, 32'h80000000, 0, 0);
    sx("R4 sfrac 0.5 sat", OP_TSF, 0, NE, 32'h3F000000, 32'h7FFFFFFF, 1, 0);
    sx("R4 ufrac 1.0 sat", OP_TUF, 0, NE, 32'h3F800000, 32'hFFFFFFFF, 1, 0);
    sx("R4 tiny ne", OP_TSF, 0, NE, 32'h2F000000, 32'h00000000, 0, 1);
    sx("R4 tiny up", OP_TSF, 0, UP, 32'h2F000000, 32'h00000001, 0, 1);
  endtask

  task automatic t_nan();
    sx("R5 qnan sint", OP_TSI, 0, NE, 32'h7FC00000, 32'h0, 1, 0);
    sx("R5 neg nan ufrac", OP_TUF, 0, UP, 32'hFFC00000, 32'h0, 1, 0);
    sx("R5 snan sint", OP_TSI, 1, NE, 32'h7F800001, 32'h0, 1, 0);
  endtask

  task automatic t_signed_sat();
    sx("R6 2^31", OP_TSI, 0, NE, 32'h4F000000, 32'h7FFFFFFF, 1, 0);
    sx("R6 -2^31", OP_TSI, 0, NE, 32'hCF000000, 32'h80000000, 0, 0);
    sx("R6 +inf", OP_TSI, 0, NE, 32'h7F800000, 32'h7FFFFFFF, 1, 0);
    sx("R6 -inf", OP_TSI, 0, NE, 32'hFF800000, 32'h80000000, 1, 0);
    sx("R6 2^33", OP_TSI, 0, NE, 32'h50000000, 32'h7FFFFFFF, 1, 0);
    sx("R6 below 2^31", OP_TSI, 0, NE, 32'h4EFFFFFF, 32'h7FFFFF80, 0, 0);
  endtask

  task automatic t_unsigned_sat();
    sx("R7 2^31", OP_TUI, 0, NE, 32'h4F000000, 32'h80000000, 0, 0);
    sx("R7 -1.5", OP_TUI, 0, NE, 32'hBFC00000, 32'h00000000, 1, 0);
    sx("R7 -0.25 ne", OP_TUI, 0, NE, 32'hBE800000, 32'h00000000, 0, 1);
    sx("R7 -0.25 dn", OP_TUI, 0, DN, 32'hBE800000, 32'h00000000, 1, 0);
    sx("R7 2^33", OP_TUI, 0, NE, 32'h50000000, 32'hFFFFFFFF, 1, 0);
    sx("R7 -inf", OP_TUI, 0, NE, 32'hFF800000, 32'h00000000, 1, 0);
  endtask

  task automatic t_zero_denorm();
    sx("R8 denorm", OP_TSI, 0, NE, 32'h00000001, 32'h0, 0, 1);
    sx("R8 neg zero", OP_TSI, 0, NE, 32'h80000000, 32'h0, 0, 0);
    sx("R8 denorm up", OP_TSI, 0, UP, 32'h00000001, 32'h0, 0, 1);
    sx("R8 neg denorm ufrac", OP_TUF, 0, DN, 32'h807FFFFF, 32'h0, 0, 1);
  endtask

  task automatic t_vector();
    xfer("R9 mixed flags", OP_TSI, 0, NE, 1'b1, {32'h40200000, 32'h7FC00000},
         {32'h00000002, 32'h00000000}, 1, 1);
    xfer("R9 from int", OP_FSI, 0, NE, 1'b1, {32'h00000001, 32'hFFFFFFFF},
         {32'h3F800000, 32'hBF800000}, 0, 0);
    xfer("R9 to ufrac", OP_TUF, 0, NE, 1'b1, {32'h3F000000, 32'h3E800000},
         {32'h80000000, 32'h40000000}, 0, 0);
  endtask

  task automatic t_scalar();
    xfer("R10 upper ignored f2i", OP_TSI, 0, NE, 1'b0, {32'h40200000, 32'h3F800000},
         {32'h0, 32'h00000001}, 0, 0);
    xfer("R10 upper ignored i2f", OP_FSI, 0, NE, 1'b0, {32'hFFFFFFFF, 32'h00000002},
         {32'h0, 32'h40000000}, 0, 0);
  endtask

  task automatic t_stall();
    @(negedge clk);
    out_ready = 1'b0;
    in_valid = 1'b1; in_op = OP_FSI; in_trunc = 0; in_rmode = NE; in_vec = 0;
    in_data = 64'h1;
    @(negedge clk);
    expect_out("R11 first accepted", 64'h3F800000, 0, 0);
    checks++;
    if (in_ready !== 1'b0) begin
      errors++; $display("FAIL R11: in_ready got %b expected 0", in_ready);
    end
    in_data = 64'h2;
    @(negedge clk);
    expect_out("R12 held during stall", 64'h3F800000, 0, 0);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    expect_out("R11 second after release", 64'h40000000, 0, 0);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R11: drain got v=%b rdy=%b expected v=0 rdy=1", out_valid, in_ready);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_from_int();
    t_from_frac();
    t_to_int();
    t_to_frac();
    t_nan();
    t_signed_sat();
    t_unsigned_sat();
    t_zero_denorm();
    t_vector();
    t_scalar();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule